// File: doc/BRIEF.md
# Polarity-Selectable Phase-Frequency Detector

This block compares two divided-down clocks: a reference tick train `ref_div_i` and a feedback tick train `fb_div_i` from the loop's programmable divider. Both arrive as level signals that are synchronous to the sampling clock `clk`. The core is a two-flag tri-state detector. A rising edge on either input raises that input's flag. When both flags are raised, both are cleared in the same cycle. The flags are mapped onto two registered pump outputs, `cp_up_o` and `cp_dn_o`, which drive an external charge pump.

The single control input `pol_hi_i` serves two purposes. It sets which flag drives which pump output, so the loop sense can be inverted for a VCO with a negative tuning slope. It also selects which of the two divided signals is copied to the monitor output `mon_o`. The tie-high default of this input on a board gives the normal sense and shows the reference on the monitor.

A lock indicator watches how long the detector stays active in each reference period. It drops at once on a wide phase error. It rises only at a reference edge that closes a full, clean period.

Top module: `pfd_polar_top`

## Requirements
- R1: While `rst` is high, and in the cycle after a reset edge, `cp_up_o`, `cp_dn_o`, `lock_o` and `mon_o` are all 0, and both detector flags are clear.
- R2: A rising edge of an input is a clock in which it reads 1 after reading 0 in the previous clock. It raises that input's flag. When the two flags would both be raised, both clear instead. A lead of k clocks gives one pump pulse exactly k clocks wide, and simultaneous edges give no pulse.
- R3: With `pol_hi_i` = 1, the reference flag drives `cp_up_o` and the feedback flag drives `cp_dn_o`, so a leading reference produces an up pulse.
- R4: With `pol_hi_i` = 0, the mapping is swapped: a leading reference produces a down pulse and a leading feedback produces an up pulse.
- R5: The pump outputs are registered and follow the detector flags one clock later.
- R6: `cp_up_o` and `cp_dn_o` are never high in the same cycle.
- R7: `mon_o` is registered and shows, one clock later, `ref_div_i` when `pol_hi_i` = 1 and `fb_div_i` when `pol_hi_i` = 0.
- R8: When the detector has been active (either flag) for more than `LOCK_TOL` consecutive clocks, `lock_o` is 0 from the next clock on. A run of exactly `LOCK_TOL` clocks leaves it unchanged.
- R9: `lock_o` rises only on the clock after a reference rising edge. That edge must close a full reference period that began with an earlier reference edge since reset and contained no run longer than `LOCK_TOL`. The first reference edge after reset therefore never raises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_div_i | input | 1 | Divided reference signal |
| fb_div_i | input | 1 | Divided feedback (VCO) signal |
| pol_hi_i | input | 1 | 1: normal sense, monitor shows reference; 0: inverted sense, monitor shows feedback |
| cp_up_o | output | 1 | Pump-up drive to external charge pump |
| cp_dn_o | output | 1 | Pump-down drive to external charge pump |
| lock_o | output | 1 | Lock indicator |
| mon_o | output | 1 | Monitor copy of the selected divided signal |

## Verification
The bench builds the block with `LOCK_TOL` = 2 rather than the default of 1. This makes the tolerance boundary visible as two separate cases: a two-clock lead that must keep lock, and a three-clock lead that must drop it. With the default, the same boundary would collapse onto the smallest possible phase offsets. Each 16-clock reference period is built from the position of its two rising edges. Leads of both signs are run under both polarity settings, so every pulse width and output mapping can be predicted from the edge positions alone.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_REF = 0;
  localparam int CH_FB  = 1;

  typedef struct packed {
    logic up;
    logic dn;
  } pump_t;

  // Map detector flags onto pump outputs according to the polarity select.
  function automatic pump_t orient(input pump_t f, input logic pol_hi);
    pump_t o;
    o.up = pol_hi ? f.up : f.dn;
    o.dn = pol_hi ? f.dn : f.up;
    return o;
  endfunction
endpackage

// File: rtl/pfd_edge.sv
module pfd_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q & ~rst;
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  rise_ref_i,
  input  logic  rise_fb_i,
  output pump_t flags_o
);
  pump_t flags_q, flags_n;

  always_comb begin
    flags_n.up = flags_q.up | rise_ref_i;
    flags_n.dn = flags_q.dn | rise_fb_i;
    if (flags_n.up && flags_n.dn) flags_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_n;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/pfd_lock.sv
module pfd_lock #(
  parameter int LOCK_TOL = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  input  logic rise_ref_i,
  output logic lock_o
);
  localparam int RUN_W = $clog2(LOCK_TOL + 2);
  localparam logic [RUN_W-1:0] TOL_V = RUN_W'(LOCK_TOL);

  logic [RUN_W-1:0] run_q;
  logic             viol_q, armed_q, lock_q;
  logic             bad;

  assign bad = active_i && (run_q == TOL_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      viol_q  <= 1'b0;
      armed_q <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      if (!active_i)           run_q <= '0;
      else if (run_q != TOL_V) run_q <= run_q + 1'b1;

      if (rise_ref_i) begin
        armed_q <= 1'b1;
        viol_q  <= bad;
        lock_q  <= armed_q & ~viol_q & ~bad;
      end else if (bad) begin
        viol_q <= 1'b1;
        lock_q <= 1'b0;
      end
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/pfd_polar_top.sv
module pfd_polar_top
  import pfd_pkg::*;
#(
  parameter int LOCK_TOL = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_div_i,
  input  logic fb_div_i,
  input  logic pol_hi_i,
  output logic cp_up_o,
  output logic cp_dn_o,
  output logic lock_o,
  output logic mon_o
);
  logic [NUM_CH-1:0] div_in, div_rise;
  pump_t             flags, pump_n;
  logic              flag_up, flag_dn;

  assign div_in[CH_REF] = ref_div_i;
  assign div_in[CH_FB]  = fb_div_i;

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_edge
      pfd_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (div_in[g]),
        .rise_o (div_rise[g])
      );
    end
  endgenerate

  pfd_core u_core (
    .clk        (clk),
    .rst        (rst),
    .rise_ref_i (div_rise[CH_REF]),
    .rise_fb_i  (div_rise[CH_FB]),
    .flags_o    (flags)
  );

  assign flag_up = flags.up;
  assign flag_dn = flags.dn;

  pfd_lock #(.LOCK_TOL(LOCK_TOL)) u_lock (
    .clk        (clk),
    .rst        (rst),
    .active_i   (flag_up | flag_dn),
    .rise_ref_i (div_rise[CH_REF]),
    .lock_o     (lock_o)
  );

  assign pump_n = orient(flags, pol_hi_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cp_up_o <= 1'b0;
      cp_dn_o <= 1'b0;
      mon_o   <= 1'b0;
    end else begin
      cp_up_o <= pump_n.up;
      cp_dn_o <= pump_n.dn;
      mon_o   <= pol_hi_i ? ref_div_i : fb_div_i;
    end
  end
endmodule

// File: rtl/pfd_polar_chk.sv
module pfd_polar_chk #(
  parameter int LOCK_TOL = 1
) (
  input logic clk,
  input logic rst,
  input logic fr,
  input logic fp,
  input logic pol,
  input logic cp_up,
  input logic cp_dn,
  input logic lock,
  input logic mon,
  input logic flag_up,
  input logic flag_dn,
  input logic rise_ref
);
  int act_run;

  always_ff @(posedge clk) begin
    if (rst)                      act_run <= 0;
    else if (!(flag_up || flag_dn)) act_run <= 0;
    else if (act_run < LOCK_TOL)  act_run <= act_run + 1;
  end

  // R6
  a_r6_never_both: assert property (@(posedge clk) disable iff (rst)
    !(cp_up && cp_dn));

  // R2
  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(flag_up && flag_dn));

  // R7
  a_r7_mon_follow: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (mon == ($past(pol) ? $past(fr) : $past(fp))));

  // R3
  a_r3_ref_drives_up: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pol) && $past(flag_up)) |-> cp_up);

  // R4
  a_r4_fb_drives_up: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pol) && $past(flag_dn)) |-> cp_up);

  // R8
  a_r8_lock_drop: assert property (@(posedge clk) disable iff (rst)
    ((flag_up || flag_dn) && act_run >= LOCK_TOL) |=> !lock);

  // R9
  a_r9_lock_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> $past(rise_ref));
endmodule

bind pfd_polar_top pfd_polar_chk #(.LOCK_TOL(LOCK_TOL)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .fr       (ref_div_i),
  .fp       (fb_div_i),
  .pol      (pol_hi_i),
  .cp_up    (cp_up_o),
  .cp_dn    (cp_dn_o),
  .lock     (lock_o),
  .mon      (mon_o),
  .flag_up  (flag_up),
  .flag_dn  (flag_dn),
  .rise_ref (div_rise[0])
);

// File: tb/pfd_polar_top_tb.sv
module pfd_polar_top_tb;
  localparam int TOL = 2;
  localparam int PER = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fr = 1'b0, fp = 1'b0, pol = 1'b1;
  logic cp_up, cp_dn, lock, mon;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit overlap_seen = 1'b0;
  logic mon_exp = 1'b0;

  typedef struct { bit up; int width; } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  pfd_polar_top #(.LOCK_TOL(TOL)) u_dut (
    .clk(clk), .rst(rst), .ref_div_i(fr), .fb_div_i(fp), .pol_hi_i(pol),
    .cp_up_o(cp_up), .cp_dn_o(cp_dn), .lock_o(lock), .mon_o(mon)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor: measures pump pulses and compares with queued items.
  task automatic pulse_done(input bit is_up, input int w);
    exp_t e;
    checks++;
    if (sb_q.size() == 0) begin
      errors++;
      $display("FAIL R2 unexpected pulse up=%0d actual=%0d expected=0 pulses", is_up, w);
    end else begin
      e = sb_q.pop_front();
      if (e.up != is_up || e.width != w) begin
        errors++;
        $display("FAIL R2/R3/R4/R5 pulse actual up=%0d width=%0d expected up=%0d width=%0d",
                 is_up, w, e.up, e.width);
      end
    end
  endtask

  int run_up = 0, run_dn = 0;
  always @(negedge clk) begin
    if (rst) begin
      run_up = 0;
      run_dn = 0;
    end else begin
      if (cp_up && cp_dn) overlap_seen = 1'b1;
      if (cp_up) run_up++;
      else if (run_up > 0) begin pulse_done(1'b1, run_up); run_up = 0; end
      if (cp_dn) run_dn++;
      else if (run_dn > 0) begin pulse_done(1'b0, run_dn); run_dn = 0; end
    end
  end

  // One reference period; edges at clock offsets fr_at / fp_at (both < PER/2).
  task automatic run_period(input int fr_at, input int fp_at, input bit p);
    int mism = 0;
    exp_t e;
    if (fr_at != fp_at) begin
      e.width = (fr_at < fp_at) ? fp_at - fr_at : fr_at - fp_at;
      e.up    = (fr_at < fp_at) ? p : !p;
      sb_q.push_back(e);
    end
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (mon !== mon_exp) mism++;
      pol = p;
      fr  = (i >= fr_at) && (i < fr_at + PER/2);
      fp  = (i >= fp_at) && (i < fp_at + PER/2);
      mon_exp = p ? fr : fp;
    end
    check(mism == 0, "R7 monitor mismatches", mism, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check({cp_up, cp_dn, lock, mon} == 4'b0, "R1 outputs in reset", {cp_up, cp_dn, lock, mon}, 0);
    rst = 1'b0;

    // R9: first reference edge after reset never raises lock
    run_period(1, 1, 1'b1);
    check(lock == 1'b0, "R9 lock after first period", lock, 0);
    run_period(1, 1, 1'b1);
    run_period(1, 1, 1'b1);
    check(lock == 1'b1, "R9 lock after clean periods", lock, 1);

    // R8: lead equal to tolerance keeps lock (up pulse, R3)
    run_period(1, 1 + TOL, 1'b1);
    check(lock == 1'b1, "R8 lock at tolerance", lock, 1);
    // R8: lead beyond tolerance drops lock
    run_period(1, 2 + TOL, 1'b1);
    check(lock == 1'b0, "R8 lock beyond tolerance", lock, 0);
    // R9: period closing the violation keeps lock low; next clean one raises it
    run_period(1, 1, 1'b1);
    check(lock == 1'b0, "R9 lock after violating period", lock, 0);
    run_period(1, 1, 1'b1);
    check(lock == 1'b1, "R9 lock regained", lock, 1);

    // R3: feedback leading -> down pulse
    run_period(5, 1, 1'b1);
    // R4: inverted polarity
    run_period(1, 3, 1'b0);
    run_period(4, 1, 1'b0);
    run_period(2, 2, 1'b0);
    run_period(3, 4, 1'b0);
    // back to normal polarity
    run_period(3, 6, 1'b1);
    run_period(6, 6, 1'b1);
    run_period(2, 3, 1'b1);

    repeat (PER) begin
      @(negedge clk);
      fr = 1'b0;
      fp = 1'b0;
    end
    check(sb_q.size() == 0, "R2 pending pulses", sb_q.size(), 0);
    check(!overlap_seen, "R6 both pumps high", overlap_seen, 0);

    // R1: reset mid-run clears lock
    run_period(1, 1, 1'b1);
    run_period(1, 1, 1'b1);
    check(lock == 1'b1, "R9 lock before reset", lock, 1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check({cp_up, cp_dn, lock, mon} == 4'b0, "R1 outputs after reset edge", {cp_up, cp_dn, lock, mon}, 0);
    rst = 1'b0;
    mon_exp = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule